// File: doc/BRIEF.md
# Content-Hash Duplicate Candidate Table

This block keeps a small table that maps a hash of a cache block's content to a short pointer (set and way) to a block in the cache that may hold the same content. The cache hands the block each freshly fetched line together with the location it is being filled into. The block folds the line into a 32-bit content code and a short table index, and looks the index up. If the entry there is valid and holds the same code, the stored pointer is returned as a duplicate candidate. The cache then reads that location, an external compare unit checks the two lines, and the compare result is returned. In every other case a fresh entry is written that points at the new fill location.

The table stays in step with cache residency. When the cache evicts a block, it sends the evicted set, way and the table index it was given when the block was looked up. The entry at that index is cleared only if it still points at the evicted location. A compare that shows a false hash match moves the entry's pointer to the newly filled block.

Fills and responses use valid/ready handshakes. A fill is taken only when `fill_ready` is high, and `fill_ready` stays low from acceptance until the transaction is over. A response, once raised, holds all of its fields stable until `res_ready` is seen. After a hit response has been taken, `cmp_ready` goes high and stays high until one compare result arrives. During that wait no new fill is accepted. Eviction notices are single-cycle pulses and are always accepted.

Top module: `dupe_hash_table`

## Requirements
- R1: After reset every table entry is invalid, `fill_ready` is 1 and `res_valid` and `cmp_ready` are 0. A fill issued right after reset reports `res_hit` = 0.
- R2: The content code is the XOR of the eight 32-bit words of the 256-bit line. Word 0 is bits 31:0. The table index is formed in two steps. First, the upper and lower 16 bits of the code are XORed. Then bit b of that 16-bit value is XORed into index bit (b mod 4). The index is reported on `res_idx`.
- R3: A fill whose indexed entry is invalid or holds a different code reports `res_hit` = 0. It writes that entry as valid, with the fill's code and the fill's set and way.
- R4: A fill whose indexed entry is valid with an equal code reports `res_hit` = 1, with the stored set and way on `res_set`/`res_way`.
- R5: A compare result with `cmp_match` = 1 leaves the entry unchanged.
- R6: A compare result with `cmp_match` = 0 rewrites the entry so that it points at the pending fill's set and way.
- R7: An eviction notice clears the entry at `ev_idx` only when that entry's pointer equals `ev_set`/`ev_way`. Otherwise it has no effect.
- R8: When an allocation or retarget writes the same index that an eviction notice names in the same cycle, the write wins and the entry ends up valid.
- R9: `fill_ready` is high only when the block is idle. The response fields stay stable while `res_valid` is high and `res_ready` is low. `cmp_ready` rises only after a hit response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fetched line is offered |
| fill_ready | output | 1 | Block can take a fetched line |
| fill_data | input | 256 | Fetched line content |
| fill_set | input | 8 | Set the line is filled into |
| fill_way | input | 1 | Way the line is filled into |
| res_valid | output | 1 | Lookup response is valid |
| res_ready | input | 1 | Consumer takes the response |
| res_hit | output | 1 | A duplicate candidate was found |
| res_set | output | 8 | Candidate set (on hit) or fill set (on miss) |
| res_way | output | 1 | Candidate way (on hit) or fill way (on miss) |
| res_idx | output | 4 | Table index of the line, kept by the cache for eviction |
| cmp_valid | input | 1 | Compare result is valid |
| cmp_ready | output | 1 | Block waits for a compare result |
| cmp_match | input | 1 | 1 when the two lines were identical |
| ev_valid | input | 1 | Eviction notice pulse |
| ev_set | input | 8 | Evicted set |
| ev_way | input | 1 | Evicted way |
| ev_idx | input | 4 | Table index recorded for the evicted line |

## Verification
The assertions assume three things about the environment. First, the cache returns exactly one compare result per hit response. Second, `fill_valid` only rises when the block can take it. Third, each eviction notice carries the index that was reported when the evicted line was looked up. The bench meets these assumptions in several ways. It waits for `fill_ready` before offering a line, and it raises `cmp_valid` only while `cmp_ready` is high. It builds every eviction from a location and index that an earlier response produced. It places content codes in chosen words of the line, so that different lines can share a code or share an index without sharing a code.

// File: rtl/dht_pkg.sv
`timescale 1ns/1ps
package dht_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RESP = 2'd1,
    ST_CMP  = 2'd2
  } dht_state_e;
endpackage

// File: rtl/dht_fold.sv
`timescale 1ns/1ps
// Folds a line into a content code, then folds the code into a table index.
module dht_fold #(
  parameter int BLK_W  = 256,
  parameter int CODE_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [BLK_W-1:0]  blk,
  output logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  idx
);
  localparam int NWORD = BLK_W / CODE_W;
  localparam int HALF  = CODE_W / 2;

  logic [HALF-1:0] half_x;

  always_comb begin
    code = '0;
    for (int w = 0; w < NWORD; w++) begin
      code = code ^ blk[w*CODE_W +: CODE_W];
    end
  end

  assign half_x = code[CODE_W-1:HALF] ^ code[HALF-1:0];

  always_comb begin
    idx = '0;
    for (int b = 0; b < HALF; b++) begin
      idx[b % IDX_W] = idx[b % IDX_W] ^ half_x[b];
    end
  end
endmodule

// File: rtl/dht_store.sv
`timescale 1ns/1ps
// Register-array table: one read port, one write port, one eviction port.
module dht_store #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 32,
  parameter int SET_W  = 8,
  parameter int WAY_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [CODE_W-1:0] rd_code,
  output logic [SET_W-1:0]  rd_set,
  output logic [WAY_W-1:0]  rd_way,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              ev_en,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic [SET_W-1:0]  ev_set,
  input  logic [WAY_W-1:0]  ev_way
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [CODE_W-1:0]  code_q [ENTRIES];
  logic [SET_W-1:0]   set_q  [ENTRIES];
  logic [WAY_W-1:0]   way_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wr_here;
    logic ev_here;
    assign wr_here = wr_en && (wr_idx == IDX_W'(e));
    assign ev_here = ev_en && (ev_idx == IDX_W'(e)) &&
                     (set_q[e] == ev_set) && (way_q[e] == ev_way);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e]  <= 1'b0;
        code_q[e] <= '0;
        set_q[e]  <= '0;
        way_q[e]  <= '0;
      end else if (wr_here) begin
        vld_q[e]  <= 1'b1;
        code_q[e] <= wr_code;
        set_q[e]  <= wr_set;
        way_q[e]  <= wr_way;
      end else if (ev_here) begin
        vld_q[e]  <= 1'b0;
      end
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_code = code_q[rd_idx];
  assign rd_set  = set_q[rd_idx];
  assign rd_way  = way_q[rd_idx];
endmodule

// File: rtl/dupe_hash_table.sv
`timescale 1ns/1ps
module dupe_hash_table #(
  parameter int BLK_W  = 256,
  parameter int CODE_W = 32,
  parameter int IDX_W  = 4,
  parameter int SET_W  = 8,
  parameter int WAY_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [BLK_W-1:0]  fill_data,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [SET_W-1:0]  res_set,
  output logic [WAY_W-1:0]  res_way,
  output logic [IDX_W-1:0]  res_idx,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic              cmp_match,
  input  logic              ev_valid,
  input  logic [SET_W-1:0]  ev_set,
  input  logic [WAY_W-1:0]  ev_way,
  input  logic [IDX_W-1:0]  ev_idx
);
  import dht_pkg::*;

  dht_state_e state_q;

  logic [CODE_W-1:0] cur_code;
  logic [IDX_W-1:0]  cur_idx;
  logic              rd_vld;
  logic [CODE_W-1:0] rd_code;
  logic [SET_W-1:0]  rd_set;
  logic [WAY_W-1:0]  rd_way;

  logic              hit_q;
  logic [SET_W-1:0]  rset_q;
  logic [WAY_W-1:0]  rway_q;
  logic [IDX_W-1:0]  pidx_q;
  logic [CODE_W-1:0] pcode_q;
  logic [SET_W-1:0]  pset_q;
  logic [WAY_W-1:0]  pway_q;

  logic              accept;
  logic              look_hit;
  logic              alloc;
  logic              retarget;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [CODE_W-1:0] wr_code;
  logic [SET_W-1:0]  wr_set;
  logic [WAY_W-1:0]  wr_way;

  dht_fold #(.BLK_W(BLK_W), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_fold (
    .blk (fill_data),
    .code(cur_code),
    .idx (cur_idx)
  );

  dht_store #(.IDX_W(IDX_W), .CODE_W(CODE_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (cur_idx),
    .rd_vld (rd_vld),
    .rd_code(rd_code),
    .rd_set (rd_set),
    .rd_way (rd_way),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_code(wr_code),
    .wr_set (wr_set),
    .wr_way (wr_way),
    .ev_en  (ev_valid),
    .ev_idx (ev_idx),
    .ev_set (ev_set),
    .ev_way (ev_way)
  );

  assign fill_ready = (state_q == ST_IDLE);
  assign res_valid  = (state_q == ST_RESP);
  assign cmp_ready  = (state_q == ST_CMP);

  assign accept   = fill_valid && fill_ready;
  assign look_hit = rd_vld && (rd_code == cur_code);
  assign alloc    = accept && !look_hit;
  assign retarget = cmp_ready && cmp_valid && !cmp_match;

  always_comb begin
    wr_en   = alloc || retarget;
    wr_idx  = cur_idx;
    wr_code = cur_code;
    wr_set  = fill_set;
    wr_way  = fill_way;
    if (retarget) begin
      wr_idx  = pidx_q;
      wr_code = pcode_q;
      wr_set  = pset_q;
      wr_way  = pway_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hit_q   <= 1'b0;
      rset_q  <= '0;
      rway_q  <= '0;
      pidx_q  <= '0;
      pcode_q <= '0;
      pset_q  <= '0;
      pway_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RESP;
          hit_q   <= look_hit;
          rset_q  <= look_hit ? rd_set : fill_set;
          rway_q  <= look_hit ? rd_way : fill_way;
          pidx_q  <= cur_idx;
          pcode_q <= cur_code;
          pset_q  <= fill_set;
          pway_q  <= fill_way;
        end
        ST_RESP: if (res_ready) begin
          state_q <= hit_q ? ST_CMP : ST_IDLE;
        end
        ST_CMP: if (cmp_valid) begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_hit = hit_q;
  assign res_set = rset_q;
  assign res_way = rway_q;
  assign res_idx = pidx_q;
endmodule

// File: rtl/dupe_hash_table_chk.sv
`timescale 1ns/1ps
module dupe_hash_table_chk #(
  parameter int IDX_W = 4,
  parameter int SET_W = 8,
  parameter int WAY_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [SET_W-1:0] fill_set,
  input logic [WAY_W-1:0] fill_way,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_hit,
  input logic [SET_W-1:0] res_set,
  input logic [WAY_W-1:0] res_way,
  input logic [IDX_W-1:0] res_idx,
  input logic             cmp_ready
);
  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) &&
      $stable(res_set) && $stable(res_way) && $stable(res_idx)));

  // R9
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_ready && (res_valid || cmp_ready)));

  // R9
  cmp_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ready) |-> $past(res_valid && res_ready && res_hit));

  // R3
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> res_valid);

  // R3
  miss_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (res_hit ||
      (res_set == $past(fill_set) && res_way == $past(fill_way))));
endmodule

bind dupe_hash_table dupe_hash_table_chk #(
  .IDX_W(IDX_W), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fill_valid(fill_valid),
  .fill_ready(fill_ready),
  .fill_set  (fill_set),
  .fill_way  (fill_way),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_set   (res_set),
  .res_way   (res_way),
  .res_idx   (res_idx),
  .cmp_ready (cmp_ready)
);

// File: tb/dupe_hash_table_tb.sv
`timescale 1ns/1ps
module dupe_hash_table_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_valid = 1'b0;
  logic         fill_ready;
  logic [255:0] fill_data = '0;
  logic [7:0]   fill_set = '0;
  logic         fill_way = 1'b0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic         res_hit;
  logic [7:0]   res_set;
  logic         res_way;
  logic [3:0]   res_idx;
  logic         cmp_valid = 1'b0;
  logic         cmp_ready;
  logic         cmp_match = 1'b0;
  logic         ev_valid = 1'b0;
  logic [7:0]   ev_set = '0;
  logic         ev_way = 1'b0;
  logic [3:0]   ev_idx = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dupe_hash_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .fill_set(fill_set), .fill_way(fill_way),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_set(res_set), .res_way(res_way), .res_idx(res_idx),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_match(cmp_match),
    .ev_valid(ev_valid), .ev_set(ev_set), .ev_way(ev_way), .ev_idx(ev_idx)
  );

  // ev=1: eviction of (set,way) at index eidx; otherwise a fill of 'code' in word 'word'
  typedef struct packed {
    logic       ev;
    logic [2:0] word;
    logic [31:0] code;
    logic [7:0] set;
    logic       way;
    logic       match;
    logic       ehit;
    logic [7:0] eset;
    logic       eway;
    logic [3:0] eidx;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 3'd0, 32'h0000_0011, 8'd5,   1'b0, 1'b1, 1'b0, 8'd0,   1'b0, 4'd0}, // R3 first alloc
    '{1'b0, 3'd0, 32'h0000_0011, 8'd9,   1'b1, 1'b1, 1'b1, 8'd5,   1'b0, 4'd0}, // R4 hit, R5 confirm
    '{1'b0, 3'd0, 32'h0000_0011, 8'd10,  1'b0, 1'b0, 1'b1, 8'd5,   1'b0, 4'd0}, // R5 kept, R6 false match
    '{1'b0, 3'd3, 32'h0000_0011, 8'd20,  1'b1, 1'b1, 1'b1, 8'd10,  1'b0, 4'd0}, // R6 retargeted, R2 word 3
    '{1'b1, 3'd0, 32'h0,         8'd5,   1'b0, 1'b0, 1'b0, 8'd0,   1'b0, 4'd0}, // R7 stale evict
    '{1'b0, 3'd0, 32'h0000_0011, 8'd30,  1'b0, 1'b1, 1'b1, 8'd10,  1'b0, 4'd0}, // R7 entry kept
    '{1'b1, 3'd0, 32'h0,         8'd10,  1'b0, 1'b0, 1'b0, 8'd0,   1'b0, 4'd0}, // R7 matching evict
    '{1'b0, 3'd0, 32'h0000_0011, 8'd40,  1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 4'd0}, // R7 cleared, R3 realloc
    '{1'b0, 3'd0, 32'h0000_0011, 8'd41,  1'b0, 1'b1, 1'b1, 8'd40,  1'b1, 4'd0}, // R4
    '{1'b0, 3'd0, 32'h0000_0022, 8'd50,  1'b0, 1'b1, 1'b0, 8'd0,   1'b0, 4'd0}, // R3 code differs
    '{1'b0, 3'd0, 32'h0000_0011, 8'd51,  1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 4'd0}, // R3 overwritten
    '{1'b0, 3'd0, 32'h0000_0011, 8'd52,  1'b0, 1'b1, 1'b1, 8'd51,  1'b1, 4'd0}, // R4
    '{1'b0, 3'd7, 32'h1234_5678, 8'd255, 1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 4'd8}, // R2 index 8
    '{1'b0, 3'd7, 32'h1234_5678, 8'd0,   1'b0, 1'b1, 1'b1, 8'd255, 1'b1, 4'd8}  // R4
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Offers a line at a negedge; returns at the negedge after acceptance.
  task automatic offer(input logic [2:0] w, input logic [31:0] c,
                       input logic [7:0] s, input logic wy);
    while (!fill_ready) @(negedge clk);
    fill_data = '0;
    fill_data[w*32 +: 32] = c;
    fill_set = s;
    fill_way = wy;
    fill_valid = 1'b1;
    @(posedge clk);
    #1 fill_valid = 1'b0;
    ev_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_txn(input logic hit, input logic m);
    res_ready = 1'b1;
    @(posedge clk);
    #1 res_ready = 1'b0;
    @(negedge clk);
    if (hit) begin
      check("R9", "cmp_ready after hit response", 32'(cmp_ready), 32'd1);
      cmp_match = m;
      cmp_valid = 1'b1;
      @(posedge clk);
      #1 cmp_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic evict(input logic [7:0] s, input logic wy, input logic [3:0] ix);
    ev_set = s;
    ev_way = wy;
    ev_idx = ix;
    ev_valid = 1'b1;
    @(posedge clk);
    #1 ev_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual done=0 expected done=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "fill_ready", 32'(fill_ready), 32'd1);
    check("R1", "res_valid",  32'(res_valid),  32'd0);
    check("R1", "cmp_ready",  32'(cmp_ready),  32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].ev) begin
        evict(VEC[i].set, VEC[i].way, VEC[i].eidx);
      end else begin
        offer(VEC[i].word, VEC[i].code, VEC[i].set, VEC[i].way);
        check("R9", $sformatf("row %0d res_valid", i), 32'(res_valid), 32'd1);
        check(VEC[i].ehit ? "R4" : "R3", $sformatf("row %0d res_hit", i),
              32'(res_hit), 32'(VEC[i].ehit));
        check(VEC[i].ehit ? "R4" : "R3", $sformatf("row %0d pointer", i),
              {23'd0, res_set, res_way},
              VEC[i].ehit ? {23'd0, VEC[i].eset, VEC[i].eway}
                          : {23'd0, VEC[i].set, VEC[i].way});
        check("R2", $sformatf("row %0d res_idx", i), 32'(res_idx), 32'(VEC[i].eidx));
        finish_txn(VEC[i].ehit, VEC[i].match);
      end
    end

    // R8: entry idx 0 is (51,1) code 0x11; allocate code 0x22 while evicting (51,1)
    ev_set = 8'd51; ev_way = 1'b1; ev_idx = 4'd0; ev_valid = 1'b1;
    offer(3'd0, 32'h22, 8'd60, 1'b0);
    check("R8", "alloc under evict hit", 32'(res_hit), 32'd0);
    finish_txn(1'b0, 1'b0);
    offer(3'd0, 32'h22, 8'd61, 1'b1);
    check("R8", "write beat eviction", 32'(res_hit), 32'd1);
    check("R8", "pointer", {24'd0, res_set}, 32'd60);
    finish_txn(1'b1, 1'b1);

    // R9 back-pressure: hold res_ready low on a hit (idx 8 -> (255,1))
    offer(3'd7, 32'h1234_5678, 8'd1, 1'b1);
    repeat (3) @(negedge clk);
    check("R9", "res_valid held", 32'(res_valid), 32'd1);
    check("R9", "fill_ready low while busy", 32'(fill_ready), 32'd0);
    check("R9", "cmp_ready low before take", 32'(cmp_ready), 32'd0);
    check("R9", "held pointer", {23'd0, res_set, res_way}, {23'd0, 8'd255, 1'b1});
    finish_txn(1'b1, 1'b1);
    check("R9", "idle after compare", 32'(fill_ready), 32'd1);

    // R1: reset empties the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "fill_ready after reset", 32'(fill_ready), 32'd1);
    offer(3'd7, 32'h1234_5678, 8'd2, 1'b0);
    check("R1", "table empty after reset", 32'(res_hit), 32'd0);
    finish_txn(1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule